// File: doc/BRIEF.md
# Pipelined Nonvolatile-Memory Command Controller

This block is the command front end of a small on-chip nonvolatile data memory. Software loads a command code, a target address and a 16-bit data word into staging registers and then launches the command by writing one to the buffer-empty flag. The staging registers form the holding stage of a two-entry queue. An active stage sits behind them. A second command can be staged and launched while the first one is still running.

Operations are paced by a slow timebase. A divider that can be written only once produces a one-cycle tick every `divisor + 1` clocks. Software picks the divisor so that the tick rate lands between 150 kHz and 200 kHz. Until the divider has been written, the block refuses every launch.

The active stage issues the command to a behavioural memory stub. It then waits a fixed number of ticks, with separate counts for program and for erase, closes the operation and retires it. Status flags report an empty holding stage, completion of all work and access errors. Two interrupt outputs follow the first two flags when their enables are set. The data registers are hidden in normal mode and open in special mode.

Top module: `nvm_cmd_ctrl`

## Requirements
- R1: After reset the status register (address 2) reads 0xC0: bit 7 is buffer-empty = 1, bit 6 is all-done = 1 and bit 4 is access-error = 0. The divider register (address 0) reads 0 and both interrupt outputs are low.
- R2: The first write to the divider register (address 0) stores the divisor in bits [DIV_W-1:0] and sets the loaded bit, bit 7. Every later write before reset is ignored.
- R3: A program command (code 0x20) lasts PROG_TICKS ticks and an erase command (code 0x41) lasts ERASE_TICKS ticks. A tick comes every divisor+1 clocks.
- R4: A launch made while the divider is unloaded sets the access-error flag. The command is discarded and no memory operation starts.
- R5: A launch clears buffer-empty. The flag returns once the command moves into the active stage. A second command launched while the first is active runs after it, in launch order.
- R6: A write to the command (address 3) or address (address 4) register while buffer-empty is clear sets access-error. The write is discarded and the staged value is kept.
- R7: All-done reads 0 while any command is staged or active, and reads 1 once both stages are empty.
- R8: Writing 1 to status bit 4 clears access-error. If an error is raised in the same cycle, the error wins.
- R9: `irq_empty` equals buffer-empty AND control bit 7, and `irq_done` equals all-done AND control bit 6 (control register at address 1).
- R10: In normal mode the data registers (address 5 high byte, address 6 low byte) read 0 and ignore writes. In special mode they can be read and written.
- R11: Launching a command code other than 0x20 or 0x41 sets access-error and discards the command.
- R12: Each accepted command produces exactly one one-cycle `mem_start` pulse. During that pulse `mem_op_erase`, `mem_addr` and `mem_wdata` carry the command's values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| special_mode | input | 1 | Opens the data registers |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register select |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data (combinational) |
| irq_empty | output | 1 | Buffer-empty interrupt |
| irq_done | output | 1 | All-done interrupt |
| mem_start | output | 1 | Operation start pulse to the array |
| mem_op_erase | output | 1 | 1 = erase, 0 = program |
| mem_addr | output | ADDR_W | Active command address |
| mem_wdata | output | 16 | Active command data |

## Verification
Two events can land on the same clock edge: the active stage retiring its command, and the holding stage handing its queued command forward. The bench provokes this by launching a second command while the first is still waiting on ticks. It then judges that both memory starts appear in launch order with their own fields, and that all-done stays low until the second one ends. A second collision is an error being raised in the same write that clears the error flag. A single status write that both launches, with the divider still unloaded, and clears the error must leave the error flag set.

// File: rtl/nvm_cmd_pkg.sv
`timescale 1ns/1ps
package nvm_cmd_pkg;
  localparam logic [7:0] OPC_PROG  = 8'h20;
  localparam logic [7:0] OPC_ERASE = 8'h41;

  localparam logic [2:0] RA_DIV  = 3'd0;
  localparam logic [2:0] RA_CTRL = 3'd1;
  localparam logic [2:0] RA_STAT = 3'd2;
  localparam logic [2:0] RA_CMD  = 3'd3;
  localparam logic [2:0] RA_ADDR = 3'd4;
  localparam logic [2:0] RA_DHI  = 3'd5;
  localparam logic [2:0] RA_DLO  = 3'd6;

  typedef enum logic [2:0] {
    SQ_IDLE,
    SQ_ISSUE,
    SQ_WAIT,
    SQ_END,
    SQ_DRAIN
  } seq_state_e;
endpackage

// File: rtl/nvm_tick_div.sv
`timescale 1ns/1ps
module nvm_tick_div #(
  parameter int DIV_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run_i,
  input  logic [DIV_W-1:0] div_i,
  output logic             tick_o
);
  logic [DIV_W-1:0] cnt_q, cnt_d;

  always_comb begin
    tick_o = run_i && (cnt_q == div_i);
    cnt_d  = cnt_q;
    if (!run_i || tick_o) cnt_d = '0;
    else                  cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/nvm_cmd_buf.sv
`timescale 1ns/1ps
module nvm_cmd_buf #(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_code_i,
  input  logic              wr_addr_i,
  input  logic              wr_dhi_i,
  input  logic              wr_dlo_i,
  input  logic [7:0]        wdata_i,
  input  logic              push_i,
  input  logic              pop_i,
  output logic              hold_valid_o,
  output logic              act_valid_o,
  output logic [7:0]        stage_code_o,
  output logic [ADDR_W-1:0] stage_addr_o,
  output logic [15:0]       stage_data_o,
  output logic [7:0]        act_code_o,
  output logic [ADDR_W-1:0] act_addr_o,
  output logic [15:0]       act_data_o
);
  logic hold_q, hold_d, act_q, act_d, xfer;

  always_comb begin
    xfer   = hold_q && (!act_q || pop_i);
    hold_d = hold_q;
    act_d  = act_q;
    if (xfer)       hold_d = 1'b0;
    else if (push_i) hold_d = 1'b1;
    if (xfer)       act_d = 1'b1;
    else if (pop_i) act_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q <= 1'b0;
      act_q  <= 1'b0;
    end else begin
      hold_q <= hold_d;
      act_q  <= act_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_code_o <= '0;
      stage_addr_o <= '0;
      stage_data_o <= '0;
    end else begin
      if (wr_code_i) stage_code_o       <= wdata_i;
      if (wr_addr_i) stage_addr_o       <= wdata_i[ADDR_W-1:0];
      if (wr_dhi_i)  stage_data_o[15:8] <= wdata_i;
      if (wr_dlo_i)  stage_data_o[7:0]  <= wdata_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_code_o <= '0;
      act_addr_o <= '0;
      act_data_o <= '0;
    end else if (xfer) begin
      act_code_o <= stage_code_o;
      act_addr_o <= stage_addr_o;
      act_data_o <= stage_data_o;
    end
  end

  assign hold_valid_o = hold_q;
  assign act_valid_o  = act_q;
endmodule

// File: rtl/nvm_op_seq.sv
`timescale 1ns/1ps
module nvm_op_seq
  import nvm_cmd_pkg::*;
#(
  parameter int PROG_TICKS  = 4,
  parameter int ERASE_TICKS = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       act_valid_i,
  input  logic [7:0] act_code_i,
  input  logic       tick_i,
  input  logic       stub_done_i,
  output logic       mem_start_o,
  output logic       mem_end_o,
  output logic       pop_o
);
  localparam int MAX_T = (PROG_TICKS > ERASE_TICKS) ? PROG_TICKS : ERASE_TICKS;
  localparam int CNT_W = $clog2(MAX_T + 1);

  seq_state_e       st_q, st_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    st_d        = st_q;
    cnt_d       = cnt_q;
    mem_start_o = 1'b0;
    mem_end_o   = 1'b0;
    pop_o       = 1'b0;
    case (st_q)
      SQ_IDLE:  if (act_valid_i) st_d = SQ_ISSUE;
      SQ_ISSUE: begin
        mem_start_o = 1'b1;
        cnt_d = (act_code_i == OPC_ERASE) ? CNT_W'(ERASE_TICKS) : CNT_W'(PROG_TICKS);
        st_d  = SQ_WAIT;
      end
      SQ_WAIT: if (tick_i) begin
        if (cnt_q <= CNT_W'(1)) begin
          cnt_d = '0;
          st_d  = SQ_END;
        end else begin
          cnt_d = cnt_q - 1'b1;
        end
      end
      SQ_END: begin
        mem_end_o = 1'b1;
        st_d      = SQ_DRAIN;
      end
      SQ_DRAIN: if (stub_done_i) begin
        pop_o = 1'b1;
        st_d  = SQ_IDLE;
      end
      default: st_d = SQ_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= SQ_IDLE;
      cnt_q <= '0;
    end else begin
      st_q  <= st_d;
      cnt_q <= cnt_d;
    end
  end
endmodule

// File: rtl/nvm_array_stub.sv
`timescale 1ns/1ps
module nvm_array_stub (
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  input  logic end_i,
  output logic busy_o,
  output logic done_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_o <= 1'b0;
      done_o <= 1'b0;
    end else begin
      if (start_i)    busy_o <= 1'b1;
      else if (end_i) busy_o <= 1'b0;
      done_o <= end_i;
    end
  end
endmodule

// File: rtl/nvm_cmd_ctrl.sv
`timescale 1ns/1ps
module nvm_cmd_ctrl
  import nvm_cmd_pkg::*;
#(
  parameter int DIV_W       = 6,
  parameter int ADDR_W      = 8,
  parameter int PROG_TICKS  = 4,
  parameter int ERASE_TICKS = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              special_mode,
  input  logic              reg_wr,
  input  logic [2:0]        reg_addr,
  input  logic [7:0]        reg_wdata,
  output logic [7:0]        reg_rdata,
  output logic              irq_empty,
  output logic              irq_done,
  output logic              mem_start,
  output logic              mem_op_erase,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [15:0]       mem_wdata
);
  logic [1:0]        rst_sync_q;
  logic              rst_int_n;
  logic [DIV_W-1:0]  div_q;
  logic              div_loaded;
  logic              ie_empty_q, ie_done_q;
  logic              err_q, err_d, err_set;
  logic              hold_valid, act_valid, hold_empty, done_flag;
  logic              wr_stat, launch_req, code_ok, push, launch_bad, stage_blocked;
  logic              wr_code, wr_addr, wr_dhi, wr_dlo;
  logic [7:0]        stage_code, act_code;
  logic [ADDR_W-1:0] stage_addr;
  logic [15:0]       stage_data;
  logic              tick, pop, mem_end, stub_busy, stub_done;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  always_comb begin
    hold_empty    = !hold_valid;
    done_flag     = !hold_valid && !act_valid;
    wr_stat       = reg_wr && (reg_addr == RA_STAT);
    launch_req    = wr_stat && reg_wdata[7] && hold_empty;
    code_ok       = (stage_code == OPC_PROG) || (stage_code == OPC_ERASE);
    push          = launch_req && div_loaded && code_ok;
    launch_bad    = launch_req && !(div_loaded && code_ok);
    stage_blocked = reg_wr && !hold_empty &&
                    ((reg_addr == RA_CMD) || (reg_addr == RA_ADDR) ||
                     (special_mode && ((reg_addr == RA_DHI) || (reg_addr == RA_DLO))));
    err_set       = launch_bad || stage_blocked;
    wr_code       = reg_wr && hold_empty && (reg_addr == RA_CMD);
    wr_addr       = reg_wr && hold_empty && (reg_addr == RA_ADDR);
    wr_dhi        = reg_wr && hold_empty && special_mode && (reg_addr == RA_DHI);
    wr_dlo        = reg_wr && hold_empty && special_mode && (reg_addr == RA_DLO);
    err_d         = err_q;
    if (err_set)                      err_d = 1'b1;
    else if (wr_stat && reg_wdata[4]) err_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      div_q      <= '0;
      div_loaded <= 1'b0;
    end else if (reg_wr && (reg_addr == RA_DIV) && !div_loaded) begin
      div_q      <= reg_wdata[DIV_W-1:0];
      div_loaded <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      ie_empty_q <= 1'b0;
      ie_done_q  <= 1'b0;
    end else if (reg_wr && (reg_addr == RA_CTRL)) begin
      ie_empty_q <= reg_wdata[7];
      ie_done_q  <= reg_wdata[6];
    end
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) err_q <= 1'b0;
    else            err_q <= err_d;
  end

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      RA_DIV: begin
        reg_rdata[7]         = div_loaded;
        reg_rdata[DIV_W-1:0] = div_q;
      end
      RA_CTRL: reg_rdata = {ie_empty_q, ie_done_q, 6'b0};
      RA_STAT: reg_rdata = {hold_empty, done_flag, 1'b0, err_q, 4'b0};
      RA_CMD:  reg_rdata = stage_code;
      RA_ADDR: reg_rdata[ADDR_W-1:0] = stage_addr;
      RA_DHI:  if (special_mode) reg_rdata = stage_data[15:8];
      RA_DLO:  if (special_mode) reg_rdata = stage_data[7:0];
      default: reg_rdata = '0;
    endcase
  end

  assign irq_empty    = ie_empty_q && hold_empty;
  assign irq_done     = ie_done_q && done_flag;
  assign mem_op_erase = (act_code == OPC_ERASE);

  nvm_tick_div #(.DIV_W(DIV_W)) u_div (
    .clk(clk), .rst_n(rst_int_n), .run_i(div_loaded), .div_i(div_q), .tick_o(tick)
  );

  nvm_cmd_buf #(.ADDR_W(ADDR_W)) u_buf (
    .clk(clk), .rst_n(rst_int_n),
    .wr_code_i(wr_code), .wr_addr_i(wr_addr), .wr_dhi_i(wr_dhi), .wr_dlo_i(wr_dlo),
    .wdata_i(reg_wdata), .push_i(push), .pop_i(pop),
    .hold_valid_o(hold_valid), .act_valid_o(act_valid),
    .stage_code_o(stage_code), .stage_addr_o(stage_addr), .stage_data_o(stage_data),
    .act_code_o(act_code), .act_addr_o(mem_addr), .act_data_o(mem_wdata)
  );

  nvm_op_seq #(.PROG_TICKS(PROG_TICKS), .ERASE_TICKS(ERASE_TICKS)) u_seq (
    .clk(clk), .rst_n(rst_int_n), .act_valid_i(act_valid), .act_code_i(act_code),
    .tick_i(tick), .stub_done_i(stub_done),
    .mem_start_o(mem_start), .mem_end_o(mem_end), .pop_o(pop)
  );

  nvm_array_stub u_stub (
    .clk(clk), .rst_n(rst_int_n), .start_i(mem_start), .end_i(mem_end),
    .busy_o(stub_busy), .done_o(stub_done)
  );
endmodule

// File: rtl/nvm_cmd_ctrl_chk.sv
`timescale 1ns/1ps
module nvm_cmd_ctrl_chk #(
  parameter int DIV_W = 6
) (
  input logic             clk,
  input logic             rst_n,
  input logic             mem_start,
  input logic             div_loaded,
  input logic [DIV_W-1:0] div_q,
  input logic             stub_busy,
  input logic             done_flag,
  input logic             err_q,
  input logic             reg_wr,
  input logic [2:0]       reg_addr,
  input logic [7:0]       reg_wdata
);
  assert_start_pulse_R12: assert property (@(posedge clk) disable iff (!rst_n)
    mem_start |=> !mem_start);

  assert_start_needs_div_R4: assert property (@(posedge clk) disable iff (!rst_n)
    mem_start |-> div_loaded);

  assert_busy_not_done_R7: assert property (@(posedge clk) disable iff (!rst_n)
    stub_busy |-> !done_flag);

  assert_div_locked_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (div_loaded && $past(div_loaded)) |-> $stable(div_q));

  assert_err_clear_by_w1c_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(err_q) |-> $past(reg_wr && (reg_addr == 3'd2) && reg_wdata[4]));
endmodule

bind nvm_cmd_ctrl nvm_cmd_ctrl_chk #(.DIV_W(DIV_W)) u_chk (
  .clk(clk), .rst_n(rst_int_n), .mem_start(mem_start), .div_loaded(div_loaded),
  .div_q(div_q), .stub_busy(stub_busy), .done_flag(done_flag), .err_q(err_q),
  .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata)
);

// File: tb/nvm_cmd_ctrl_test.sv
`timescale 1ns/1ps
module nvm_cmd_ctrl_test;
  localparam int PT = 4;
  localparam int ET = 8;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       special_mode = 1'b0;
  logic       reg_wr = 1'b0;
  logic [2:0] reg_addr = 3'd0;
  logic [7:0] reg_wdata = 8'd0;
  logic [7:0] reg_rdata;
  logic       irq_empty, irq_done, mem_start, mem_op_erase;
  logic [7:0] mem_addr;
  logic [15:0] mem_wdata;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  logic        log_op   [64];
  logic [7:0]  log_addr [64];
  logic [15:0] log_data [64];
  int          log_n = 0;
  int          exp_n = 0;
  int          cur_div = 0;

  nvm_cmd_ctrl #(.DIV_W(6), .ADDR_W(8), .PROG_TICKS(PT), .ERASE_TICKS(ET)) uut (
    .clk(clk), .rst_n(rst_n), .special_mode(special_mode), .reg_wr(reg_wr),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .irq_empty(irq_empty), .irq_done(irq_done), .mem_start(mem_start),
    .mem_op_erase(mem_op_erase), .mem_addr(mem_addr), .mem_wdata(mem_wdata)
  );

  always #2 clk = ~clk;

  always @(negedge clk) begin
    if (mem_start && log_n < 64) begin
      log_op[log_n]   <= mem_op_erase;
      log_addr[log_n] <= mem_addr;
      log_data[log_n] <= mem_wdata;
      log_n <= log_n + 1;
    end
  end

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(4 * 150000);
    checks++;
    errors++;
    $display("FAIL watchdog actual=hung expected=finished");
    summary();
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic check_range(input string req, input int act, input int lo, input int hi);
    checks++;
    if (act < lo || act > hi) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d..%0d", req, act, lo, hi);
    end
  endtask

  // all tasks start and end on a falling edge
  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    reg_addr = a;
    #1 d = reg_rdata;
    @(negedge clk);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  function automatic int lo_bound(input int n, input int d);
    return (n - 1) * (d + 1) + 5;
  endfunction
  function automatic int hi_bound(input int n, input int d);
    return n * (d + 1) + 8;
  endfunction

  task automatic stage(input logic [7:0] code, input logic [7:0] a, input logic [15:0] dat);
    wr(3'd3, code);
    wr(3'd4, a);
    wr(3'd5, dat[15:8]);
    wr(3'd6, dat[7:0]);
  endtask

  task automatic wait_done(output int k);
    logic [7:0] s;
    k = 0;
    s = 8'h00;
    while (!s[6]) begin
      rd(3'd2, s);
      if (!s[6]) k++;
    end
  endtask

  task automatic run_one(input string req, input bit erase, input logic [7:0] a, input logic [15:0] dat);
    int k;
    stage(erase ? 8'h41 : 8'h20, a, dat);
    wr(3'd2, 8'h80);
    wait_done(k);
    check_range({req, " duration"}, k, lo_bound(erase ? ET : PT, cur_div), hi_bound(erase ? ET : PT, cur_div));
    repeat (2) @(negedge clk);
    check({req, " start count"}, log_n, exp_n + 1);
    if (log_n > exp_n) begin
      check({req, " op"}, log_op[exp_n], erase);
      check({req, " addr"}, log_addr[exp_n], a);
      check({req, " data"}, log_data[exp_n], dat);
    end
    exp_n = log_n;
  endtask

  initial begin
    logic [7:0] v;
    int k;
    void'($urandom(32'h5EED));
    @(negedge clk);
    do_reset();

    // R1 reset state
    rd(3'd2, v); check("R1 status", v, 8'hC0);
    rd(3'd0, v); check("R1 divider", v, 8'h00);
    check("R1 irqs", {irq_empty, irq_done}, 2'b00);

    // R4 launch without divider
    wr(3'd3, 8'h20);
    wr(3'd2, 8'h80);
    rd(3'd2, v); check("R4 error set", v, 8'hD0);
    repeat (8) @(negedge clk);
    check("R4 no start", log_n, 0);
    // R8 clear, then set-wins collision
    wr(3'd2, 8'h10);
    rd(3'd2, v); check("R8 w1c", v, 8'hC0);
    wr(3'd2, 8'h90);
    rd(3'd2, v); check("R8 set wins", v, 8'hD0);
    wr(3'd2, 8'h10);

    // R2 write-once divider
    wr(3'd0, 8'h03); cur_div = 3;
    rd(3'd0, v); check("R2 first write", v, 8'h83);
    wr(3'd0, 8'h09);
    rd(3'd0, v); check("R2 locked", v, 8'h83);

    // R11 bad code
    wr(3'd3, 8'h33);
    wr(3'd2, 8'h80);
    rd(3'd2, v); check("R11 bad code", v, 8'hD0);
    repeat (6) @(negedge clk);
    check("R11 no start", log_n, 0);
    wr(3'd2, 8'h10);

    // R10 data register access
    wr(3'd5, 8'hAB);
    rd(3'd5, v); check("R10 normal read", v, 8'h00);
    special_mode = 1'b1;
    rd(3'd5, v); check("R10 normal write ignored", v, 8'h00);
    wr(3'd5, 8'hAB); wr(3'd6, 8'hCD);
    rd(3'd5, v); check("R10 special hi", v, 8'hAB);
    rd(3'd6, v); check("R10 special lo", v, 8'hCD);

    // R3 / R12 timing and handoff
    run_one("R3 R12 program", 1'b0, 8'h5A, 16'hABCD);
    run_one("R3 R12 erase", 1'b1, 8'hC3, 16'h1234);

    // R9 interrupts idle
    wr(3'd1, 8'hC0);
    check("R9 irqs idle", {irq_empty, irq_done}, 2'b11);

    // R5 R6 R7 queued pair
    stage(8'h20, 8'h11, 16'h0F0F);
    wr(3'd2, 8'h80);
    check("R9 irqs held", {irq_empty, irq_done}, 2'b00);
    wr(3'd4, 8'h77);                  // lands while holding stage is full
    rd(3'd2, v); check("R5 R6 R7 after move", v, 8'h90);
    rd(3'd4, v); check("R6 addr kept", v, 8'h11);
    wr(3'd2, 8'h10);
    stage(8'h41, 8'h33, 16'hBEEF);
    wr(3'd2, 8'h80);
    rd(3'd2, v); check("R5 R7 queued", v, 8'h00);
    check("R9 irq empty low", irq_empty, 1'b0);
    wait_done(k);
    repeat (2) @(negedge clk);
    check("R5 two starts", log_n, exp_n + 2);
    if (log_n >= exp_n + 2) begin
      check("R5 first addr", log_addr[exp_n], 8'h11);
      check("R5 first op", log_op[exp_n], 1'b0);
      check("R5 second addr", log_addr[exp_n + 1], 8'h33);
      check("R5 second data", log_data[exp_n + 1], 16'hBEEF);
    end
    exp_n = log_n;
    check("R9 irq done", irq_done, 1'b1);
    wr(3'd1, 8'h00);
    check("R9 irqs disabled", {irq_empty, irq_done}, 2'b00);

    // random commands
    for (int i = 0; i < 6; i++) begin
      bit e;
      logic [7:0] a;
      logic [15:0] d;
      e = 1'($urandom);
      a = 8'($urandom);
      d = 16'($urandom);
      run_one("R3 R12 random", e, a, d);
    end

    // new divisor after reset
    do_reset();
    exp_n = log_n;
    rd(3'd2, v); check("R1 status again", v, 8'hC0);
    wr(3'd0, 8'h09); cur_div = 9;
    rd(3'd0, v); check("R2 reload after reset", v, 8'h89);
    run_one("R3 slow program", 1'b0, 8'h42, 16'h5555);
    run_one("R3 slow erase", 1'b1, 8'h24, 16'hAAAA);

    summary();
  end
endmodule